// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the MAC-side station-management controller for the two-wire management interface (MDC clock, bidirectional MDIO data). The host presents a PHY address, a register address, an operation (read or write) and, for writes, a 16-bit data word, then pulses `start` for one clock. The block produces MDC from the system clock through a runtime-programmable divider. It serialises the frame on `mdio_o`, with `mdio_oe` controlling the external tri-state buffer.

A frame carries an optional 32-bit preamble of ones, a start field, an opcode, both addresses and a turnaround field, then 16 data bits. On a write the master drives every bit. On a read it releases the line from the turnaround onward and samples the PHY's data on rising MDC. The captured word is presented on `rd_data` together with a one-clock `done` strobe.

A preamble-suppression input shortens the frame from 64 MDC cycles to 32. The `busy` output covers the whole frame. Start requests made while busy are dropped.

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy`, `done`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.
- R2: `mdc` is low whenever `busy` is low.
- R3: With `suppress_pre` = 0, the frame opens with 32 bits of value 1 and lasts 64 MDC cycles. With `suppress_pre` = 1 it has no preamble and lasts 32 MDC cycles.
- R4: After any preamble the master sends the start field 0 then 1. It then sends the opcode: 1 then 0 for a read (`op_read` = 1), or 0 then 1 for a write.
- R5: After the opcode come the 5-bit `phy_addr` and then the 5-bit `reg_addr`, each most significant bit first.
- R6: On a write, the turnaround is driven as 1 then 0, followed by `wr_data` MSB first. `mdio_oe` is high for every bit of a write frame.
- R7: On a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. `mdio_i` is sampled at each rising MDC of the last 16 bits, MSB first. The word appears on `rd_data` when `done` is high. A write leaves `rd_data` unchanged.
- R8: While a frame is in progress, `mdio_o` and `mdio_oe` change only in the clock where `mdc` falls. `mdio_oe` is low whenever `busy` is low.
- R9: Each MDC half period lasts `half_period` system clocks, with 0 treated as 1. `busy` is therefore high for (frame bits × 2 × half period) clocks.
- R10: `done` is high for exactly one clock: the first clock in which `busy` is low after a frame.
- R11: A `start` pulse while `busy` is high is ignored. It changes neither the frame being sent nor its length, and it does not begin another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | DIV_W | System clocks per MDC half period (0 acts as 1) |
| start | input | 1 | One-clock request to launch a frame |
| op_read | input | 1 | 1 = read, 0 = write |
| suppress_pre | input | 1 | 1 = omit the 32-bit preamble |
| phy_addr | input | PHY_AW | Target PHY address |
| reg_addr | input | REG_AW | Target register address |
| wr_data | input | DATA_W | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame strobe |
| rd_data | output | DATA_W | Last word captured by a read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data towards the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO tri-state buffer |
| mdio_i | input | 1 | Serial data from the line |

## Verification
The properties assume that `half_period` and the frame fields are held steady while a frame runs. They also assume that `mdio_i`, as driven by the PHY, changes only after a falling MDC. The stimulus sets the fields and divider in the same clock as `start` and never touches the divider mid-frame; the one deliberate exception is the rejected start pulse. The bench plays the PHY: it updates `mdio_i` only on the clock after it sees MDC fall, so the value is stable across the following rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // two-bit codes sent on the wire, first bit in the MSB
   typedef enum logic [1:0] {
      MDIO_OP_WRITE = 2'b01,
      MDIO_OP_READ  = 2'b10
   } mdio_op_e;

   localparam logic [1:0] MDIO_SOF      = 2'b01;
   localparam logic [1:0] MDIO_TA_DRIVE = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_period,
   output logic             mdc,
   output logic             tick_rise,
   output logic             tick_fall
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   cnt_inc;
   logic             tick;

   assign cnt_inc   = {1'b0, cnt} + 1'b1;
   assign tick      = run && (cnt_inc >= {1'b0, half_period});
   assign tick_rise = tick && !mdc;
   assign tick_fall = tick && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt_inc[DIV_W-1:0];
      end
   end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
   parameter int PRE_LEN = 32,
   parameter int FRAME_W = 32,
   parameter int HDR_W   = 14,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               go_read,
   input  logic               go_skip,
   input  logic [FRAME_W-1:0] go_frame,
   input  logic               tick_rise,
   input  logic               tick_fall,
   input  logic               mdio_i,
   output logic               busy,
   output logic               done,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int IDX_W = $clog2(PRE_LEN + FRAME_W + 1);
   localparam int FI_W  = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] PRE_I   = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(FRAME_W - 1);
   localparam logic [IDX_W-1:0] DATA0_I = IDX_W'(FRAME_W - DATA_W);
   localparam logic [IDX_W-1:0] HDR_I   = IDX_W'(HDR_W);

   logic               read_q, skip_q;
   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   bit_cnt;
   logic [DATA_W-1:0]  rd_sr;

   logic               launch, sel_read, sel_skip, in_pre, in_data, is_last;
   logic [FRAME_W-1:0] sel_frame;
   logic [IDX_W-1:0]   nxt_idx, nxt_off, cur_off, f_nxt;
   logic [FI_W-1:0]    f_sel;
   logic               nxt_o, nxt_oe;

   // the next bit position is computed the same way at launch and at each fall
   always_comb begin
      launch    = go && !busy;
      sel_read  = launch ? go_read  : read_q;
      sel_skip  = launch ? go_skip  : skip_q;
      sel_frame = launch ? go_frame : frame_q;
      nxt_idx   = launch ? '0 : bit_cnt + 1'b1;
      nxt_off   = sel_skip ? '0 : PRE_I;
      in_pre    = nxt_idx < nxt_off;
      f_nxt     = nxt_idx - nxt_off;
      f_sel     = FI_W'(LAST_I - f_nxt);
      nxt_o     = in_pre || sel_frame[f_sel];
      nxt_oe    = !sel_read || in_pre || (f_nxt < HDR_I);
      cur_off   = skip_q ? '0 : PRE_I;
      in_data   = bit_cnt >= (cur_off + DATA0_I);
      is_last   = bit_cnt == (cur_off + LAST_I);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         read_q  <= 1'b0;
         skip_q  <= 1'b0;
         frame_q <= '0;
         bit_cnt <= '0;
         rd_sr   <= '0;
         rd_data <= '0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            busy    <= 1'b1;
            read_q  <= go_read;
            skip_q  <= go_skip;
            frame_q <= go_frame;
            bit_cnt <= '0;
            mdio_o  <= nxt_o;
            mdio_oe <= nxt_oe;
         end else if (busy) begin
            if (tick_rise && read_q && in_data)
               rd_sr <= {rd_sr[DATA_W-2:0], mdio_i};
            if (tick_fall) begin
               if (is_last) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  mdio_o  <= 1'b1;
                  mdio_oe <= 1'b0;
                  if (read_q)
                     rd_data <= rd_sr;
               end else begin
                  bit_cnt <= nxt_idx;
                  mdio_o  <= nxt_o;
                  mdio_oe <= nxt_oe;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int DIV_W   = 8,
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32,
   parameter bit PRE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_period,
   input  logic              start,
   input  logic              op_read,
   input  logic              suppress_pre,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   import mdio_pkg::*;

   localparam int HDR_W   = 4 + PHY_AW + REG_AW;
   localparam int FRAME_W = HDR_W + 2 + DATA_W;

   if (DIV_W < 1) begin : g_bad_div
      $error("mdio_master: DIV_W must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("mdio_master: DATA_W must be at least 2");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("mdio_master: PRE_LEN must be at least 1");
   end

   logic               skip;
   logic               tick_rise, tick_fall;
   logic [FRAME_W-1:0] frame;
   mdio_op_e           op;

   if (PRE_EN) begin : g_pre_opt
      assign skip = suppress_pre;
   end else begin : g_pre_never
      assign skip = 1'b1;
   end

   assign op    = op_read ? MDIO_OP_READ : MDIO_OP_WRITE;
   assign frame = {MDIO_SOF, op, phy_addr, reg_addr,
                   op_read ? 2'b00 : MDIO_TA_DRIVE,
                   op_read ? {DATA_W{1'b0}} : wr_data};

   mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .half_period(half_period),
      .mdc        (mdc),
      .tick_rise  (tick_rise),
      .tick_fall  (tick_fall)
   );

   mdio_frame_seq #(
      .PRE_LEN(PRE_LEN),
      .FRAME_W(FRAME_W),
      .HDR_W  (HDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (start),
      .go_read  (op_read),
      .go_skip  (skip),
      .go_frame (frame),
      .tick_rise(tick_rise),
      .tick_fall(tick_fall),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .done     (done),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);
   // R2: the management clock rests low outside a frame
   a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R8: the buffer is never enabled while idle
   a_r8_oe_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   // R8: line values move only together with a falling MDC
   a_r8_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R7: once released inside a frame, the line stays released
   a_r7_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mdio_oe) |=> !mdio_oe);

   // R10: the strobe follows the end of a frame
   a_r10_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10: the strobe lasts one clock
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .mdc    (mdc),
   .mdio_o (mdio_o),
   .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {read, skip, phy[4:0], reg[4:0], data[15:0], half[7:0]}
   localparam logic [35:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 5'h01, 5'h00, 16'hA5C3, 8'd2},
      {1'b1, 1'b0, 5'h1F, 5'h1F, 16'h8001, 8'd1},
      {1'b0, 1'b1, 5'h10, 5'h01, 16'hFFFF, 8'd3},
      {1'b1, 1'b1, 5'h00, 5'h10, 16'h0000, 8'd2},
      {1'b1, 1'b0, 5'h15, 5'h0A, 16'h7FFE, 8'd0},
      {1'b0, 1'b1, 5'h0A, 5'h15, 16'h0001, 8'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  half_period = 8'd1;
   logic        start = 1'b0;
   logic        op_read = 1'b0;
   logic        suppress_pre = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] wr_data = '0;
   logic        mdio_i = 1'b1;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [15:0] last_rd = '0;

   mdio_master u_dut (
      .clk(clk), .rst_n(rst_n), .half_period(half_period), .start(start),
      .op_read(op_read), .suppress_pre(suppress_pre), .phy_addr(phy_addr),
      .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
      .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected wire bit for MDC cycle r; cls: 0 preamble, 1 start/op, 2 address, 3 write tail, 4 released
   task automatic exp_bit(input int r, input bit rd, input bit skip, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] d,
                          output bit v, output int cls);
      int off = skip ? 0 : 32;
      int f = r - off;
      v = 1'b1;
      if (r < off) cls = 0;
      else if (f < 4) begin
         cls = 1;
         case (f)
            0: v = 1'b0;
            1: v = 1'b1;
            2: v = rd;
            default: v = !rd;
         endcase
      end else if (f < 9)  begin cls = 2; v = pa[8 - f]; end
      else if (f < 14)     begin cls = 2; v = ra[13 - f]; end
      else if (rd)         begin cls = 4; v = 1'b0; end
      else if (f == 14)    begin cls = 3; v = 1'b1; end
      else if (f == 15)    begin cls = 3; v = 1'b0; end
      else                 begin cls = 3; v = d[31 - f]; end
   endtask

   task automatic run_txn(input bit rd, input bit skip, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] d, input logic [7:0] hp, input bit inject);
      int nbits = skip ? 32 : 64;
      int hh = (hp == 0) ? 1 : int'(hp);
      int busy_cyc = 0, rises = 0, guard = 0;
      int e_pre = 0, e_hdr = 0, e_addr = 0, e_wr = 0, e_oe = 0;
      bit prev_mdc = 1'b0;
      bit v;
      int cls;
      @(negedge clk);
      op_read = rd; suppress_pre = skip; phy_addr = pa; reg_addr = ra;
      wr_data = d; half_period = hp; start = 1'b1; mdio_i = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy && guard < 100000) begin
         guard++;
         busy_cyc++;
         if (mdc && !prev_mdc) begin
            exp_bit(rises, rd, skip, pa, ra, d, v, cls);
            if (cls == 4) begin
               if (mdio_oe !== 1'b0) e_oe++;
            end else if (mdio_oe !== 1'b1 || mdio_o !== v) begin
               case (cls)
                  0: e_pre++;
                  1: e_hdr++;
                  2: e_addr++;
                  default: e_wr++;
               endcase
            end
            rises++;
         end
         if (!mdc && prev_mdc && rd && rises >= nbits - 16 && rises < nbits)
            mdio_i = d[15 - (rises - (nbits - 16))];
         prev_mdc = mdc;
         if (inject && busy_cyc == 5) begin
            start = 1'b1; op_read = !rd; suppress_pre = !skip;
            phy_addr = ~pa; reg_addr = ~ra; wr_data = ~d;
         end
         if (inject && busy_cyc == 6) start = 1'b0;
         @(negedge clk);
      end
      chk(rises == nbits, "R3 MDC cycles per frame", rises, nbits);
      chk(e_pre == 0, "R3 preamble bits", e_pre, 0);
      chk(e_hdr == 0, "R4 start/opcode bits", e_hdr, 0);
      chk(e_addr == 0, "R5 address bits", e_addr, 0);
      if (!rd) chk(e_wr == 0, "R6 turnaround/data bits", e_wr, 0);
      else     chk(e_oe == 0, "R7 line released", e_oe, 0);
      chk(busy_cyc == nbits * 2 * hh, "R9 busy length", busy_cyc, nbits * 2 * hh);
      chk(done == 1'b1, "R10 done strobe", done, 1);
      if (rd) last_rd = d;
      chk(rd_data == last_rd, "R7 rd_data", rd_data, last_rd);
      mdio_i = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R10 done one clock", done, 0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2/R8 idle line", {mdc, mdio_oe}, 0);
      if (inject) begin
         repeat (3) @(negedge clk);
         chk(busy == 1'b0, "R11 start while busy ignored", busy, 0);
      end
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 reset outputs",
          {busy, done, mdc, mdio_oe}, 0);
      chk(rd_data == 16'h0, "R1 reset rd_data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 after release",
          {busy, done, mdc, mdio_oe}, 0);

      for (int i = 0; i < NVEC; i++) begin
         run_txn(VEC[i][35], VEC[i][34], VEC[i][33:29], VEC[i][28:24],
                 VEC[i][23:8], VEC[i][7:0], i == 2);
      end

      // R11: rejected start on a read frame with preamble
      run_txn(1'b1, 1'b0, 5'h03, 5'h11, 16'hC0DE, 8'd1, 1'b1);

      // R1: reset in the middle of a frame
      @(negedge clk);
      op_read = 1'b0; suppress_pre = 1'b0; half_period = 8'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(busy == 0 && mdc == 0 && mdio_oe == 0, "R1 reset mid-frame",
          {busy, mdc, mdio_oe}, 0);
      chk(rd_data == 16'h0, "R1 reset clears rd_data", rd_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule